// File: doc/BRIEF.md
# Received Frame Word Storage Sequencer

This block copies a received frame from the protocol core into the receive memory. The frame is presented as a wide parallel vector of fixed-size words. When the core signals that a frame is valid, the sequencer issues one memory write per clock. The first write goes out in the same cycle as the valid pulse, and the next words follow back to back. No per-word handshake is used, because the core holds the frame vector steady for longer than the longest burst. After the end-of-frame event the bus spends at least three bit times in intermission, and each bit lasts at least seven clocks, so the data stays put for at least 21 cycles.

A length input sets how many words of the frame are stored. A base address input sets where the burst starts in the receive memory, and the address wraps at the memory depth. Word k of the frame is `frame_data_i[k*32 +: 32]` with the default 32-bit words, so word 0 sits in the lowest bits. When the last word has been written, the block gives a one-cycle completion pulse. A valid pulse that arrives while a burst is still running is dropped and reported on a one-cycle overrun pulse.

Top module: `rx_frame_stash`

## Requirements
- R1: When `frame_valid_i` is 1 and no burst is running, `mem_we_o` is 1 in that same cycle. In that cycle `mem_addr_o` equals `base_addr_i` and `mem_wdata_o` equals word 0, which is bits [31:0] of `frame_data_i`.
- R2: The remaining words are written in the following consecutive cycles, one per cycle, with no gap. The write for word k carries bits [32k+31:32k] of `frame_data_i`.
- R3: The number of words written equals `word_count_i` for values 1 to 20. A value of 0 writes one word, and values above 20 write 20 words.
- R4: The write address for word k is (base + k) modulo `MEM_DEPTH` (64 by default). The base is the value of `base_addr_i` captured in the start cycle.
- R5: `done_o` is 1 for exactly the one cycle that follows the final word write of a burst, and it is 1 at no other time.
- R6: A `frame_valid_i` pulse during a running burst is ignored: the addresses and data of that burst do not change, and no extra writes happen. `overrun_o` is 1 for the single cycle after such a pulse.
- R7: `busy_o` is 1 from the cycle after the start through the cycle of the final write, and 0 in the cycle after the final write. A new frame is accepted in that cycle, so bursts can run back to back.
- R8: While `rst_n` is low, and after it is released with no valid pulse, `mem_we_o`, `done_o`, `overrun_o` and `busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Pulse from the protocol core: a frame is ready |
| frame_data_i | input | 640 | Received frame, word k at bits [32k+31:32k] |
| word_count_i | input | 5 | Number of words to store (1 to 20, clamped) |
| base_addr_i | input | 6 | Memory address of word 0 |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 6 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse after the final write |
| overrun_o | output | 1 | One-cycle pulse after a dropped valid |

## Verification
A word index that is off by one, or a base that is not latched, shows up at the ports within the cycle of the affected write. It appears as a wrong `mem_addr_o` or `mem_wdata_o`, and the scoreboard catches it on the first mismatched pop. A wrong copy of the burst length shows either as a write with no queued entry, or as entries left over at the end together with a `done_o` that is early or late by the same number of cycles. A busy flag that is stuck or cleared too early shows up one cycle later: `busy_o` has the wrong value, a dropped pulse starts a new burst and its writes go to foreign addresses, or `overrun_o` fails to rise.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Number of words actually stored for a raw length request.
  function automatic logic [31:0] clamp_len(input logic [31:0] raw, input logic [31:0] max_words);
    if (raw == 32'd0)          return 32'd1;
    else if (raw > max_words)  return max_words;
    else                       return raw;
  endfunction

  // Memory slot of word idx for a burst starting at base.
  function automatic logic [31:0] slot_of(input logic [31:0] base, input logic [31:0] idx,
                                          input logic [31:0] depth);
    return (base + idx) % depth;
  endfunction

endpackage

// File: rtl/rxs_seq_ctrl.sv
module rxs_seq_ctrl #(
  parameter int FRAME_WORDS = 20,
  localparam int IDX_W = $clog2(FRAME_WORDS),
  localparam int LEN_W = $clog2(FRAME_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid_i,
  input  logic [LEN_W-1:0] len_words_i,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             start_evt_o,
  output logic             last_evt_o,
  output logic             drop_evt_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overrun_o
);
  logic             busy_q, done_q, ovr_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [LEN_W-1:0] len_m1;
  logic [IDX_W-1:0] start_last, cur_last;

  assign len_m1      = len_words_i - LEN_W'(1);
  assign start_last  = IDX_W'(len_m1);
  assign start_evt_o = frame_valid_i & ~busy_q;
  assign drop_evt_o  = frame_valid_i & busy_q;
  assign we_o        = start_evt_o | busy_q;
  assign idx_o       = busy_q ? idx_q : '0;
  assign cur_last    = busy_q ? last_q : start_last;
  assign last_evt_o  = we_o & (idx_o == cur_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= last_evt_o;
      ovr_q  <= drop_evt_o;
      if (last_evt_o) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (start_evt_o) begin
        busy_q <= 1'b1;
        idx_q  <= IDX_W'(1);
        last_q <= start_last;
      end else if (busy_q) begin
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rxs_addr_gen.sv
module rxs_addr_gen #(
  parameter int FRAME_WORDS = 20,
  parameter int MEM_DEPTH   = 64,
  localparam int IDX_W  = $clog2(FRAME_WORDS),
  localparam int ADDR_W = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, eff_base;
  logic [31:0]       slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           base_q <= '0;
    else if (start_evt_i) base_q <= base_i;
  end

  assign eff_base = start_evt_i ? base_i : base_q;
  assign slot     = rxs_pkg::slot_of(32'(eff_base), 32'(idx_i), 32'(MEM_DEPTH));
  assign addr_o   = ADDR_W'(slot);
endmodule

// File: rtl/rxs_word_sel.sv
module rxs_word_sel #(
  parameter int FRAME_WORDS = 20,
  parameter int WORD_W      = 32,
  localparam int IDX_W = $clog2(FRAME_WORDS)
) (
  input  logic [FRAME_WORDS*WORD_W-1:0] frame_i,
  input  logic [IDX_W-1:0]              idx_i,
  output logic [WORD_W-1:0]             word_o
);
  logic [WORD_W-1:0] words [FRAME_WORDS];

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slice
    assign words[g] = frame_i[g*WORD_W +: WORD_W];
  end

  assign word_o = (32'(idx_i) < FRAME_WORDS) ? words[idx_i] : '0;
endmodule

// File: rtl/rx_frame_stash.sv
module rx_frame_stash #(
  parameter int FRAME_WORDS = 20,
  parameter int WORD_W      = 32,
  parameter int MEM_DEPTH   = 64,
  localparam int IDX_W  = $clog2(FRAME_WORDS),
  localparam int LEN_W  = $clog2(FRAME_WORDS + 1),
  localparam int ADDR_W = $clog2(MEM_DEPTH),
  localparam int DATA_W = FRAME_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic [LEN_W-1:0]  word_count_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              overrun_o
);
  logic [LEN_W-1:0] len_eff;
  logic [IDX_W-1:0] word_idx;
  logic             start_evt, last_evt, drop_evt;

  assign len_eff = LEN_W'(rxs_pkg::clamp_len(32'(word_count_i), 32'(FRAME_WORDS)));

  rxs_seq_ctrl #(.FRAME_WORDS(FRAME_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_valid_i(frame_valid_i), .len_words_i(len_eff),
    .we_o(mem_we_o), .idx_o(word_idx), .start_evt_o(start_evt), .last_evt_o(last_evt),
    .drop_evt_o(drop_evt), .busy_o(busy_o), .done_o(done_o), .overrun_o(overrun_o)
  );

  rxs_addr_gen #(.FRAME_WORDS(FRAME_WORDS), .MEM_DEPTH(MEM_DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .base_i(base_addr_i),
    .idx_i(word_idx), .addr_o(mem_addr_o)
  );

  rxs_word_sel #(.FRAME_WORDS(FRAME_WORDS), .WORD_W(WORD_W)) u_sel (
    .frame_i(frame_data_i), .idx_i(word_idx), .word_o(mem_wdata_o)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_valid_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              overrun_o,
  input logic              start_evt,
  input logic              last_evt,
  input logic              drop_evt
);
  p_first_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid_i && !busy_o) |-> mem_we_o);

  p_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !last_evt) |=> mem_we_o);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !last_evt) |=> (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

  p_done_follows_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> done_o);

  p_done_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_evt));

  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> overrun_o);

  p_overrun_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(busy_o && frame_valid_i));

  p_drop_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !start_evt);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !frame_valid_i) |-> !mem_we_o);

  p_busy_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !busy_o);
endmodule

bind rx_frame_stash rxs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_valid_i(frame_valid_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .busy_o(busy_o), .done_o(done_o), .overrun_o(overrun_o),
  .start_evt(start_evt), .last_evt(last_evt), .drop_evt(drop_evt)
);

// File: tb/sim_rx_frame_stash.sv
module sim_rx_frame_stash;
  localparam int CLK_P = 10;
  localparam int NW = 20;
  localparam int WW = 32;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int ITEM_W = 1 + AW + WW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fv = 1'b0;
  logic [NW*WW-1:0] frame = '0;
  logic [4:0] wcount = '0;
  logic [AW-1:0] base = '0;
  logic we, busy, done, ovr;
  logic [AW-1:0] addr;
  logic [WW-1:0] wdata;

  int total = 0, bad = 0, writes_seen = 0, writes_exp = 0;
  bit finished = 0, prev_last = 0;
  logic [ITEM_W-1:0] sb[$];

  always #(CLK_P/2) clk = ~clk;

  rx_frame_stash u0 (
    .clk(clk), .rst_n(rst_n), .frame_valid_i(fv), .frame_data_i(frame),
    .word_count_i(wcount), .base_addr_i(base), .mem_we_o(we), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .busy_o(busy), .done_o(done), .overrun_o(ovr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: pops the scoreboard on every write, checks the completion pulse.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_last || done) check("R5 done pulse", 64'(done), 64'(prev_last));
      if (we) begin
        writes_seen++;
        if (sb.size() == 0) begin
          check("R3/R6 unexpected write", 64'(1), 64'(0));
          prev_last = 0;
        end else begin
          logic [ITEM_W-1:0] it;
          it = sb.pop_front();
          check("R1/R2/R4 address", 64'(addr), 64'(it[WW +: AW]));
          check("R1/R2 data", 64'(wdata), 64'(it[WW-1:0]));
          prev_last = it[ITEM_W-1];
        end
      end else prev_last = 0;
    end
  end

  // Driver: builds the frame, queues the expected writes, runs the burst.
  task automatic run_frame(input int b, input int len, input int seed, input int drop_at);
    int n;
    n = (len == 0) ? 1 : ((len > NW) ? NW : len);
    for (int k = 0; k < NW; k++)
      frame[k*WW +: WW] = WW'(seed * 32'h0100_0193) ^ WW'(k * 32'h9E37_79B9);
    for (int k = 0; k < n; k++)
      sb.push_back({(k == n-1), AW'((b + k) % DEPTH), frame[k*WW +: WW]});
    writes_exp += n;
    base = AW'(b); wcount = 5'(len); fv = 1'b1;
    wait_cycles(1);
    fv = 1'b0; base = AW'(b + 17); wcount = 5'd3;
    @(negedge clk);
    if (n > 1) check("R7 busy during burst", 64'(busy), 64'(1));
    if (drop_at >= 0) begin
      wait_cycles(drop_at);
      fv = 1'b1;
      wait_cycles(1);
      fv = 1'b0;
      @(negedge clk);
      check("R6 overrun pulse", 64'(ovr), 64'(1));
      wait_cycles(n - 2 - drop_at);
    end else begin
      wait_cycles(n - 1);
    end
    @(negedge clk);
    check("R7 idle after burst", 64'(busy), 64'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset we", 64'(we), 64'(0));
    check("R8 reset busy", 64'(busy), 64'(0));
    rst_n = 1'b1;
    wait_cycles(2);
    @(negedge clk);
    check("R8 idle done", 64'(done), 64'(0));
    check("R8 idle overrun", 64'(ovr), 64'(0));
    wait_cycles(1);
    run_frame(0, 20, 1, -1);   // full frame
    wait_cycles(2);
    run_frame(5, 1, 2, -1);    // single word, R3
    wait_cycles(1);
    run_frame(9, 0, 3, -1);    // zero length clamps to one, R3
    wait_cycles(1);
    run_frame(30, 31, 4, -1);  // oversize length clamps to twenty, R3
    wait_cycles(1);
    run_frame(60, 8, 5, -1);   // address wrap, R4
    wait_cycles(1);
    run_frame(12, 10, 6, 2);   // dropped valid mid burst, R6
    wait_cycles(1);
    run_frame(40, 10, 7, 8);   // dropped valid on the final write, R6
    run_frame(50, 4, 8, -1);   // back to back start, R7
    run_frame(20, 1, 9, -1);
    run_frame(21, 1, 10, 0 - 1);
    wait_cycles(4);
    check("R3 total words written", 64'(writes_seen), 64'(writes_exp));
    check("R2 scoreboard drained", 64'(sb.size()), 64'(0));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule